// File: doc/BRIEF.md
# Random-Access Scan Array

This block holds a bank of state cells that sit between the combinational logic of a design and its feedback paths. Instead of linking the cells into a serial shift chain, each cell is reached on its own through a decoded address. In functional mode the bank acts as an ordinary register and every cell takes its input from the logic on each clock. In scan mode exactly one cell, named by an address register, is written from a shared serial data line, and its content appears on a shared serial output.

The address register is loaded one bit at a time from a dedicated input while its shift enable is high. Because a scan access changes at most one cell, the block supports tests in which a single state bit changes between two functional clocks. Addresses at or beyond the cell count select nothing, so a tester can park the address safely. The cell bank is cleared by an asynchronous active-low reset.

Top module: `ras_array`

## Requirements
- R1: The address register is ADDR_W = ceil(log2 NFF) bits wide; on each clock with addr_shift_i high it shifts left by one, taking addr_si_i into bit 0, so the address is sent most significant bit first.
- R2: The decoder selects at most one cell at a time, and address k (k < NFF) selects cell k, whose value is q_o[k].
- R3: In scan mode (test_mode_i = 1) with addr_shift_i low, the selected cell loads scan_in_i on the clock and every other cell keeps its value.
- R4: scan_out_o equals the content of the selected cell, combinationally, so it reflects a new address in the same cycle the address register changes.
- R5: In functional mode (test_mode_i = 0), every cell loads its bit of d_i on each clock.
- R6: When the address is NFF or above, no cell is written in scan mode and scan_out_o is 0.
- R7: In scan mode, a clock with addr_shift_i high changes no cell.
- R8: While rst_ni is low, all cells and the address register are cleared: q_o is 0, scan_out_o is 0, and the first scan write after reset goes to cell 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 1 | 1 = scan access, 0 = functional capture |
| addr_shift_i | input | 1 | Shift enable for the address register |
| addr_si_i | input | 1 | Serial address bit |
| scan_in_i | input | 1 | Shared scan write data |
| d_i | input | NFF | Functional next-state from the logic |
| q_o | output | NFF | Cell contents to the logic |
| scan_out_o | output | 1 | Content of the selected cell |

## Verification
Every cycle, assertions check that the select lines are at most one-hot, that out-of-range addresses select nothing and read zero, that unselected cells hold during scan writes, that address shifts leave all cells unchanged, and that functional mode captures d_i. Only the bench scenarios show that a serially loaded address lands on the intended cell with the intended bit order, that the read path follows the address in the same cycle, and that reset leaves the address at zero so the first write goes to cell 0.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic {
    MODE_FUNC = 1'b0,
    MODE_SCAN = 1'b1
  } ras_mode_e;

  function automatic int addr_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ras_addr_reg.sv
module ras_addr_reg #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;

  generate
    if (ADDR_W == 1) begin : g_narrow
      assign addr_d = shift_i ? bit_i : addr_q;
    end else begin : g_wide
      assign addr_d = shift_i ? {addr_q[ADDR_W-2:0], bit_i} : addr_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/ras_decoder.sv
module ras_decoder #(
  parameter int NFF    = 12,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NFF-1:0]    sel_o
);
  for (genvar k = 0; k < NFF; k++) begin : g_sel
    assign sel_o[k] = (addr_i == ADDR_W'(k));
  end
endmodule

// File: rtl/ras_cell.sv
module ras_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scan_i,
  input  logic sel_i,
  input  logic hold_i,
  input  logic d_i,
  input  logic si_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    if (!scan_i)              q_d = d_i;
    else if (sel_i && !hold_i) q_d = si_i;
    else                      q_d = q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/ras_readout.sv
module ras_readout #(
  parameter int NFF = 12
) (
  input  logic [NFF-1:0] sel_i,
  input  logic [NFF-1:0] q_i,
  output logic           so_o
);
  assign so_o = |(sel_i & q_i);
endmodule

// File: rtl/ras_array.sv
module ras_array #(
  parameter int NFF = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           test_mode_i,
  input  logic           addr_shift_i,
  input  logic           addr_si_i,
  input  logic           scan_in_i,
  input  logic [NFF-1:0] d_i,
  output logic [NFF-1:0] q_o,
  output logic           scan_out_o
);
  import ras_pkg::*;

  localparam int ADDR_W = addr_width(NFF);
  localparam logic [ADDR_W:0] NFF_L = (ADDR_W+1)'(NFF);

  ras_mode_e         mode;
  logic [ADDR_W-1:0] addr;
  logic [NFF-1:0]    sel;
  logic [NFF-1:0]    q;
  logic              scan_en;

  assign mode    = ras_mode_e'(test_mode_i);
  assign scan_en = (mode == MODE_SCAN);

  ras_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (addr_shift_i),
    .bit_i   (addr_si_i),
    .addr_o  (addr)
  );

  ras_decoder #(.NFF(NFF), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr),
    .sel_o  (sel)
  );

  for (genvar k = 0; k < NFF; k++) begin : g_cell
    ras_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .scan_i (scan_en),
      .sel_i  (sel[k]),
      .hold_i (addr_shift_i),
      .d_i    (d_i[k]),
      .si_i   (scan_in_i),
      .q_o    (q[k])
    );
  end

  ras_readout #(.NFF(NFF)) u_rd (
    .sel_i (sel),
    .q_i   (q),
    .so_o  (scan_out_o)
  );

  assign q_o = q;

  // select lines never name two cells
  p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));

  // out-of-range address selects nothing and reads zero
  p_oor_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, addr} >= NFF_L) |-> (sel == '0 && !scan_out_o));

  // unselected cells hold across a scan write
  p_unsel_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode_i && !addr_shift_i) |=> (((q_o ^ $past(q_o)) & ~$past(sel)) == '0));

  // selected cell takes scan data
  p_sel_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode_i && !addr_shift_i && sel != '0) |=>
      ((q_o & $past(sel)) == ($past(scan_in_i) ? $past(sel) : '0)));

  // address shift leaves the bank untouched
  p_shift_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode_i && addr_shift_i) |=> $stable(q_o));

  // functional capture
  p_func_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_i |=> (q_o == $past(d_i)));

  // read path reflects the selected cell
  p_read_path_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel != '0) |-> (scan_out_o == |(q_o & sel)));
endmodule

// File: tb/ras_array_bench.sv
module ras_array_bench;
  localparam int NFF    = 12;
  localparam int ADDR_W = $clog2(NFF);
  localparam int AMASK  = (1 << ADDR_W) - 1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           tm, sh, asi, si;
  logic [NFF-1:0] d;
  logic [NFF-1:0] q;
  logic           so;

  logic [NFF-1:0] eq;
  int             eaddr;
  int             n_chk = 0;
  int             n_fail = 0;
  bit             done = 0;

  always #10 clk = ~clk;

  ras_array #(.NFF(NFF)) u_ras_array (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .test_mode_i  (tm),
    .addr_shift_i (sh),
    .addr_si_i    (asi),
    .scan_in_i    (si),
    .d_i          (d),
    .q_o          (q),
    .scan_out_o   (so)
  );

  function automatic logic exp_so();
    return (eaddr < NFF) ? eq[eaddr] : 1'b0;
  endfunction

  task automatic chk(input string req, input logic [NFF-1:0] act, input logic [NFF-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: update model at the edge, then check outputs
  task automatic tick(input string rq, input string rso);
    @(posedge clk);
    if (!tm) eq = d;
    else if (!sh && eaddr < NFF) eq[eaddr] = si;
    if (sh) eaddr = ((eaddr << 1) | int'(asi)) & AMASK;
    #2;
    chk(rq, q, eq);
    chk(rso, NFF'(so), NFF'(exp_so()));
  endtask

  task automatic shift_addr(input int a);
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      tm = 1'b1; sh = 1'b1; asi = a[i]; si = ~si; d = NFF'($urandom);
      tick("R7 shift holds cells", "R1 R4 address read");
    end
  endtask

  task automatic scan_write(input logic b, input string tag);
    tm = 1'b1; sh = 1'b0; si = b; d = NFF'($urandom);
    tick(tag, "R4 readback");
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; tm = 1'b0; sh = 1'b0; asi = 1'b0; si = 1'b0; d = '1;
    eq = '0; eaddr = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R8 reset q", q, '0);
    chk("R8 reset scan_out", NFF'(so), '0);
    @(negedge clk);
    rst_n = 1'b1;

    // first write after reset hits cell 0
    scan_write(1'b1, "R8 first write to cell 0");
    chk("R8 cell0 set", q, NFF'(1));

    // functional capture
    tm = 1'b0; sh = 1'b0; d = 12'hA5C; tick("R5 capture", "R4 read");
    d = 12'h3F1;                       tick("R5 capture", "R4 read");

    // address 5, toggle it
    shift_addr(5);
    scan_write(~eq[5], "R3 write cell 5");
    scan_write(~eq[5], "R3 write cell 5 again");

    // last cell
    shift_addr(NFF - 1);
    scan_write(1'b1, "R2 R3 write top cell");
    scan_write(1'b0, "R2 R3 clear top cell");

    // out of range addresses
    shift_addr(NFF);
    scan_write(1'b1, "R6 no write at NFF");
    chk("R6 scan_out zero", NFF'(so), '0);
    shift_addr(AMASK);
    scan_write(1'b1, "R6 no write at max");
    scan_write(1'b0, "R6 no write at max");

    // bit order: address 1 then 8
    shift_addr(1);
    scan_write(~eq[1], "R1 MSB-first addr 1");
    shift_addr(8);
    scan_write(~eq[8], "R1 MSB-first addr 8");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      tm  = ($urandom % 4) != 0;
      sh  = ($urandom % 3) == 0;
      asi = 1'(($urandom % 4) == 0 ? 1 : 0) ^ 1'($urandom % 2);
      si  = 1'($urandom);
      d   = NFF'($urandom);
      tick("R3 R5 R6 R7 random", "R2 R4 random read");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule